// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block decides which output queue of a single port is allowed to send next. Each queue has a small priority code in a configuration table that is written one entry at a time. The code picks a weight or marks the queue as static priority. The block turns each weight into an 8-bit participation pattern, one bit per round. A round counter then walks through eight rounds. In each round, the non-empty queues whose pattern bit for that round is set are served once each, in ascending index order.

A group of queues at the low end of the index range can be marked static priority. A non-empty static queue always wins over the weighted queues, and within the static group the lowest index wins. A grant is presented with a one-hot vector and an index. It stays put until the consumer accepts it. A configuration-error flag reports a code out of range or a static group that is split or does not begin at queue 0.

Top module: `wrr_queue_sched`

## Requirements
- R1: After reset, no grant is offered (`gnt_valid` low), `cfg_err` is low, and every table entry holds priority code 8.
- R2: Priority codes map to round-participation patterns as 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF, 9→0xFF, and any code above 9 maps to 0xFF. Bit r of the pattern allows the queue into round r, so a continuously backlogged weighted queue is granted once per set bit over one full pass of rounds 0 to 7.
- R3: A weighted queue whose pattern is 0x00 is never granted.
- R4: Any table entry holding a code above 9 drives `cfg_err` high from the cycle after the write.
- R5: Code 9 marks a queue static. `cfg_err` is high whenever some static queue i>0 has a non-static queue i-1 immediately below it.
- R6: When any static queue is non-empty at a decision, the lowest-index non-empty static queue is granted, ahead of all weighted queues.
- R7: In round r, the weighted queue granted is the lowest-index non-empty, non-static queue with pattern bit r set whose index lies above the last weighted queue granted in this round. When no such queue exists but some non-empty weighted queue has a non-zero pattern, the decision cycle grants nothing, the round advances (7 wraps to 0), and the search restarts at queue 0.
- R8: While `gnt_valid` is high and `gnt_accept` is low, `gnt_idx` and `gnt_onehot` stay unchanged, and `gnt_onehot` has exactly bit `gnt_idx` set.
- R9: A grant that is accepted drops `gnt_valid` at the next clock edge. The next decision is taken on the edge after that.
- R10: If no static queue is non-empty and no non-empty weighted queue has a non-zero pattern, `gnt_valid` stays low and the round counter keeps its value.
- R11: A table write (`cfg_we` high, entry `cfg_addr`, code `cfg_prio`) takes effect for decisions made from the following clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | QW | Queue entry to write |
| cfg_prio | input | 4 | Priority code to write (0-8 weight, 9 static) |
| q_nonempty | input | N_Q | Per-queue backlog flags |
| gnt_accept | input | 1 | Consumer takes the current grant |
| gnt_valid | output | 1 | A grant is being offered |
| gnt_onehot | output | N_Q | One-hot grant vector |
| gnt_idx | output | QW | Index of the granted queue |
| cfg_err | output | 1 | Table holds an illegal code or a badly placed static group |

## Verification
The bench targets the points where the round walk can go wrong. One is the wrap from round 7 back to 0. A design that skipped the idle advance cycle or left the pointer unreset would serve queues out of order or grant twice in one round. Another is a backlog made only of zero-weight queues. There the round must freeze, and a design that kept advancing would make later grants land in the wrong round. Static queues that become backlogged while weighted traffic is flowing are checked for pre-emption. Split static groups and out-of-range codes are checked for the error flag. A single full pass of rounds is tallied per queue against the pattern popcounts, which catches any pattern that was mis-encoded.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;

   localparam int PRIO_W      = 4;
   localparam int ROUNDS      = 8;
   localparam int RND_W       = 3;
   localparam int STATIC_CODE = 9;
   localparam int RESET_CODE  = 8;

   typedef logic [PRIO_W-1:0] prio_t;
   typedef logic [ROUNDS-1:0] pattern_t;

   // weight code to spread-out round participation pattern
   function automatic pattern_t code_to_pattern(input prio_t code);
      pattern_t p;
      case (code)
         4'd0:    p = 8'h00;
         4'd1:    p = 8'h01;
         4'd2:    p = 8'h11;
         4'd3:    p = 8'h49;
         4'd4:    p = 8'h55;
         4'd5:    p = 8'h57;
         4'd6:    p = 8'h77;
         4'd7:    p = 8'h7F;
         default: p = 8'hFF;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/wrr_cfg_table.sv
module wrr_cfg_table
   import wrr_sched_pkg::*;
#(
   parameter int N_Q = 8,
   parameter int QW  = 3
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [QW-1:0]          wr_sel,
   input  prio_t                  wr_code,
   output pattern_t [N_Q-1:0]     patterns,
   output logic     [N_Q-1:0]     is_static,
   output logic                   bad_cfg
);

   logic [N_Q-1:0] code_hi;
   logic [N_Q-1:0] gap_below;

   for (genvar q = 0; q < N_Q; q++) begin : g_entry
      prio_t code_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            code_q <= prio_t'(RESET_CODE);
         else if (wr_en && (int'(wr_sel) == q))
            code_q <= wr_code;
      end

      assign patterns[q]  = code_to_pattern(code_q);
      assign is_static[q] = (code_q == prio_t'(STATIC_CODE));
      assign code_hi[q]   = (code_q > prio_t'(STATIC_CODE));

      if (q == 0) begin : g_first
         assign gap_below[q] = 1'b0;
      end else begin : g_rest
         assign gap_below[q] = is_static[q] & ~is_static[q-1];
      end
   end

   assign bad_cfg = (|code_hi) | (|gap_below);

endmodule

// File: rtl/wrr_first_from.sv
module wrr_first_from #(
   parameter int N_Q = 8,
   parameter int QW  = 3,
   parameter int PW  = 4
)(
   input  logic [N_Q-1:0] cand,
   input  logic [PW-1:0]  start,
   output logic           found,
   output logic [QW-1:0]  sel
);

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int i = N_Q - 1; i >= 0; i--) begin
         if (cand[i] && (i >= int'(start))) begin
            found = 1'b1;
            sel   = QW'(i);
         end
      end
   end

endmodule

// File: rtl/wrr_queue_sched.sv
module wrr_queue_sched
   import wrr_sched_pkg::*;
#(
   parameter int N_Q = 8,
   localparam int QW = (N_Q > 1) ? $clog2(N_Q) : 1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [QW-1:0]  cfg_addr,
   input  logic [3:0]     cfg_prio,
   input  logic [N_Q-1:0] q_nonempty,
   input  logic           gnt_accept,
   output logic           gnt_valid,
   output logic [N_Q-1:0] gnt_onehot,
   output logic [QW-1:0]  gnt_idx,
   output logic           cfg_err
);

   localparam int PW = $clog2(N_Q + 1);

   if (N_Q < 1 || N_Q > 32) begin : g_bad_nq
      $error("wrr_queue_sched: N_Q must lie in 1..32");
   end

   pattern_t [N_Q-1:0] patterns;
   logic     [N_Q-1:0] st_vec;
   logic     [N_Q-1:0] wt_now;
   logic     [N_Q-1:0] wt_any;
   logic     [N_Q-1:0] st_cand;
   logic     [RND_W-1:0] round_q;
   logic     [PW-1:0]  pos_q;
   logic               st_found, wt_found;
   logic     [QW-1:0]  st_sel, wt_sel;

   wrr_cfg_table #(.N_Q(N_Q), .QW(QW)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_sel   (cfg_addr),
      .wr_code  (cfg_prio),
      .patterns (patterns),
      .is_static(st_vec),
      .bad_cfg  (cfg_err)
   );

   for (genvar q = 0; q < N_Q; q++) begin : g_elig
      assign wt_now[q] = q_nonempty[q] & ~st_vec[q] & patterns[q][round_q];
      assign wt_any[q] = q_nonempty[q] & ~st_vec[q] & (|patterns[q]);
   end
   assign st_cand = q_nonempty & st_vec;

   wrr_first_from #(.N_Q(N_Q), .QW(QW), .PW(PW)) u_pick_static (
      .cand (st_cand),
      .start('0),
      .found(st_found),
      .sel  (st_sel)
   );

   wrr_first_from #(.N_Q(N_Q), .QW(QW), .PW(PW)) u_pick_weighted (
      .cand (wt_now),
      .start(pos_q),
      .found(wt_found),
      .sel  (wt_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_valid  <= 1'b0;
         gnt_idx    <= '0;
         gnt_onehot <= '0;
         round_q    <= '0;
         pos_q      <= '0;
      end else if (gnt_valid) begin
         if (gnt_accept)
            gnt_valid <= 1'b0;
      end else if (st_found) begin
         gnt_valid  <= 1'b1;
         gnt_idx    <= st_sel;
         gnt_onehot <= N_Q'(1) << st_sel;
      end else if (wt_found) begin
         gnt_valid  <= 1'b1;
         gnt_idx    <= wt_sel;
         gnt_onehot <= N_Q'(1) << wt_sel;
         pos_q      <= PW'(wt_sel) + PW'(1);
      end else if (|wt_any) begin
         round_q <= round_q + RND_W'(1);
         pos_q   <= '0;
      end
   end

endmodule

// File: rtl/wrr_sched_checker.sv
module wrr_sched_checker #(
   parameter int N_Q = 8,
   parameter int QW  = 3
)(
   input logic           clk,
   input logic           rst_n,
   input logic [N_Q-1:0] q_nonempty,
   input logic           gnt_accept,
   input logic           gnt_valid,
   input logic [N_Q-1:0] gnt_onehot,
   input logic [QW-1:0]  gnt_idx,
   input logic [N_Q-1:0] st_vec
);

   AST_ONEHOT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> ($onehot0(gnt_onehot) && gnt_onehot[gnt_idx])); // R8

   AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !gnt_accept) |=> (gnt_valid && $stable(gnt_idx) && $stable(gnt_onehot))); // R8

   AST_ACCEPT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && gnt_accept) |=> !gnt_valid); // R9

   AST_GRANT_BACKLOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> ((($past(q_nonempty) >> gnt_idx) & N_Q'(1)) != '0)); // R7

   AST_STATIC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gnt_valid) && (($past(q_nonempty) & $past(st_vec)) != '0))
         |-> ((($past(st_vec) >> gnt_idx) & N_Q'(1)) != '0)); // R6

endmodule

bind wrr_queue_sched wrr_sched_checker #(.N_Q(N_Q), .QW(QW)) u_sched_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .q_nonempty(q_nonempty),
   .gnt_accept(gnt_accept),
   .gnt_valid (gnt_valid),
   .gnt_onehot(gnt_onehot),
   .gnt_idx   (gnt_idx),
   .st_vec    (st_vec)
);

// File: tb/wrr_queue_sched_bench.sv
module wrr_queue_sched_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int QW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [QW-1:0] cfg_addr = '0;
   logic [3:0]    cfg_prio = '0;
   logic [N-1:0]  q_nonempty = '0;
   logic          gnt_accept = 1'b0;
   logic          gnt_valid;
   logic [N-1:0]  gnt_onehot;
   logic [QW-1:0] gnt_idx;
   logic          cfg_err;

   int tests = 0, fails = 0, cycles = 0;
   int prio [N];
   int mv, midx, mround, mpos;
   int tally [N];
   int tally_state;   // 0 idle, 1 waiting for round 0, 2 counting, 3 done

   always #(CLK_PERIOD/2) clk = ~clk;

   wrr_queue_sched #(.N_Q(N)) u_wrr_queue_sched (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_prio(cfg_prio), .q_nonempty(q_nonempty), .gnt_accept(gnt_accept),
      .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_idx(gnt_idx),
      .cfg_err(cfg_err)
   );

   function automatic int pat(input int c);
      case (c)
         0: return 'h00;  1: return 'h01;  2: return 'h11;  3: return 'h49;
         4: return 'h55;  5: return 'h57;  6: return 'h77;  7: return 'h7F;
         default: return 'hFF;
      endcase
   endfunction

   function automatic int popc(input int v);
      int c = 0;
      for (int b = 0; b < 8; b++) c += (v >> b) & 1;
      return c;
   endfunction

   function automatic int model_err();
      for (int i = 0; i < N; i++) begin
         if (prio[i] > 9) return 1;
         if (i > 0 && prio[i] == 9 && prio[i-1] != 9) return 1;
      end
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // advance the model across one clock edge with the current inputs
   task automatic model_next();
      int found, any_wt, sidx, widx;
      if (mv) begin
         if (gnt_accept) mv = 0;
      end else begin
         found = 0; any_wt = 0; sidx = -1; widx = -1;
         for (int i = N - 1; i >= 0; i--)
            if (q_nonempty[i] && prio[i] == 9) sidx = i;
         for (int i = N - 1; i >= mpos; i--)
            if (q_nonempty[i] && prio[i] != 9 && ((pat(prio[i]) >> mround) & 1)) widx = i;
         for (int i = 0; i < N; i++)
            if (q_nonempty[i] && prio[i] != 9 && pat(prio[i]) != 0) any_wt = 1;
         if (sidx >= 0) begin
            mv = 1; midx = sidx;
         end else if (widx >= 0) begin
            mv = 1; midx = widx; mpos = widx + 1;
            if (tally_state == 2) tally[widx]++;
         end else if (any_wt) begin
            mround = (mround + 1) % 8;
            mpos = 0;
            if (mround == 0) begin
               if (tally_state == 1) tally_state = 2;
               else if (tally_state == 2) tally_state = 3;
            end
         end
      end
      if (cfg_we) prio[cfg_addr] = cfg_prio;
   endtask

   task automatic compare();
      check(gnt_valid == mv[0], "R9 R10 gnt_valid", gnt_valid, mv);
      if (mv) begin
         check(gnt_idx == QW'(midx), "R2 R6 R7 gnt_idx", gnt_idx, midx);
         check(gnt_onehot == (N'(1) << midx), "R8 gnt_onehot", gnt_onehot, 1 << midx);
      end
      check(cfg_err == model_err()[0], "R4 R5 R11 cfg_err", cfg_err, model_err());
   endtask

   task automatic tick();
      model_next();
      @(negedge clk);
      compare();
   endtask

   task automatic write_prio(input int q, input int c);
      cfg_we = 1'b1; cfg_addr = QW'(q); cfg_prio = 4'(c);
      tick();
      cfg_we = 1'b0;
   endtask

   initial begin : watchdog
      while (cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < N; i++) begin prio[i] = 8; tally[i] = 0; end
      mv = 0; midx = 0; mround = 0; mpos = 0; tally_state = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(gnt_valid == 1'b0, "R1 valid after reset", gnt_valid, 0);
      check(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);

      // default weights, all backlogged, immediate accept
      q_nonempty = '1;
      gnt_accept = 1'b1;
      repeat (60) tick();

      // R2 R3: weights 0..7, tally one complete pass of rounds
      for (int i = 0; i < N; i++) write_prio(i, i);
      tally_state = 1;
      repeat (500) tick();
      check(tally_state == 3, "R7 full pass reached", tally_state, 3);
      for (int i = 0; i < N; i++)
         check(tally[i] == popc(pat(i)), "R2 grants per pass", tally[i], popc(pat(i)));
      check(tally[0] == 0, "R3 zero-weight queue never granted", tally[0], 0);

      // R8: hold grant without accept
      gnt_accept = 1'b0;
      repeat (10) tick();
      gnt_accept = 1'b1;
      repeat (4) tick();

      // R6: static group 0..1 pre-empts weighted traffic
      write_prio(0, 9);
      write_prio(1, 9);
      for (int k = 0; k < 200; k++) begin
         q_nonempty = N'($urandom);
         gnt_accept = 1'($urandom);
         tick();
      end

      // R5: static queue above a non-static one
      write_prio(1, 8);
      check(cfg_err == 1'b0, "R5 contiguous static ok", cfg_err, 0);
      write_prio(3, 9);
      check(cfg_err == 1'b1, "R5 split static group", cfg_err, 1);
      write_prio(3, 4);
      write_prio(0, 4);
      // R4: code above 9
      write_prio(5, 12);
      check(cfg_err == 1'b1, "R4 code above 9", cfg_err, 1);
      q_nonempty = 8'h20;
      gnt_accept = 1'b1;
      repeat (30) tick();
      write_prio(5, 3);
      check(cfg_err == 1'b0, "R4 error clears", cfg_err, 0);

      // R10: only zero-weight or empty queues -> no grant, round frozen
      write_prio(2, 0);
      q_nonempty = 8'h04;
      repeat (25) tick();
      check(gnt_valid == 1'b0, "R10 no eligible queue", gnt_valid, 0);
      q_nonempty = 8'h00;
      repeat (10) tick();
      q_nonempty = 8'h48;
      repeat (40) tick();

      // random mixed traffic with random legal tables
      for (int blk = 0; blk < 20; blk++) begin
         int ns;
         ns = $urandom_range(0, 3);
         for (int i = 0; i < N; i++)
            write_prio(i, (i < ns) ? 9 : $urandom_range(0, 8));
         for (int k = 0; k < 150; k++) begin
            q_nonempty = N'($urandom) & N'($urandom);
            gnt_accept = ($urandom_range(0, 3) != 0);
            tick();
         end
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule